// File: doc/BRIEF.md
# Interrupt and status register unit

This unit holds the status and control registers that a storage-card host controller exposes to software through a 32-bit register port. It collects single-cycle event pulses from the command sequencer, the data path and the DMA engine into a raw interrupt status word. It combines that word with a software mask and a global interrupt enable to drive one interrupt line.

The unit also follows card insertion and removal. It keeps a remaining-byte counter for the current transfer and raises data-complete when that counter reaches zero. It keeps a small DMA status word whose low ten bits software can clear. Reads are registered: a read strobe in one cycle presents its data on the following cycle and holds it until the next read.

Top module: `irqs_unit`

## Requirements
- R1: After reset these offsets read as follows: control 0x000 = 0x300, timeout 0x008 = 0xFFFFFF40, block size 0x010 = 0x200, byte count 0x014 = 0x200, mask 0x030 = 0, raw status 0x038 = 0, DMA status 0x088 = 0. Status 0x03C reads 0x104 when data_ready is low. The interrupt line is low.
- R2: Bits 0, 1 and 2 of the control register at 0x000 are never stored, so they always read back as 0. The other written bits are kept.
- R3: A read of 0x034 returns the raw status ANDed with the mask at 0x030. A read of 0x038 returns the raw status without masking.
- R4: A write to 0x034 or to 0x038 clears every raw status bit whose data bit is 1 and leaves the other bits unchanged.
- R5: irq is high exactly when control bit 4 is 1 and (raw & mask) is nonzero. It takes its new value on the same clock edge as the registers it depends on.
- R6: Each event pulse sets one raw bit: ev_no_resp sets bit 1, ev_cmd_done bit 2, ev_data_done bit 3, ev_auto_done bit 14 and ev_sdio bit 16.
- R7: card_insert sets raw bit 30, clears raw bit 31 and sets status bit 8. card_remove sets raw bit 31, clears raw bit 30 and clears status bit 8. If both arrive in the same cycle, insertion wins.
- R8: A write to 0x014 stores the byte-count register and loads the remaining counter. Each xfer_pulse subtracts xfer_bytes from the counter, saturating at 0. Any pulse whose result is 0 sets raw bit 3. A load in the same cycle as a pulse takes priority, and that pulse is dropped.
- R9: A write to 0x03C clears the stored status bits whose data bit is 1.
- R10: A status read adds bit 2 when data_ready is low and adds bit 17 when data_ready is high.
- R11: dma_tx_done sets DMA status bits 0 and 8, and dma_rx_done sets bits 1 and 8. A write to 0x088 clears the bits among 0..9 whose data bit is 1. Bits 10 and up always read 0.
- R12: When an event sets a status bit in the same cycle as a write that clears it, the bit ends up set.
- R13: reg_rdata changes only on the cycle after a reg_rd strobe and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_no_resp | input | 1 | Command got no valid response |
| ev_cmd_done | input | 1 | Command finished |
| ev_data_done | input | 1 | Data phase finished |
| ev_auto_done | input | 1 | Automatic stop command finished |
| ev_sdio | input | 1 | Card-side interrupt or DMA finish |
| card_insert | input | 1 | Card inserted |
| card_remove | input | 1 | Card removed |
| xfer_pulse | input | 1 | A chunk of data moved |
| xfer_bytes | input | CNT_W | Size of that chunk in bytes |
| dma_tx_done | input | 1 | DMA transmit finished |
| dma_rx_done | input | 1 | DMA receive finished |
| data_ready | input | 1 | Card data waiting to be read |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land in one cycle: an event pulse setting a status bit, and a software write clearing that same bit. The bench provokes this by raising ev_cmd_done and card_insert in the same cycle as a write of 1s to those bits at the raw offset. It then judges the result by reading raw status back and checking that irq stays high. The byte counter has the same kind of collision, a load arriving with a decrement pulse. The bench checks it by confirming that no data-complete appears until a later pulse drains the loaded value.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_TMO     = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_BLKSZ   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_BCNT    = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_IMASK   = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_ISTAT_M = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_ISTAT_R = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_STATE   = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_DSTAT   = 12'h088;

  localparam int B_NORESP  = 1;
  localparam int B_CMDDONE = 2;
  localparam int B_DATDONE = 3;
  localparam int B_AUTODN  = 14;
  localparam int B_SDIO    = 16;
  localparam int B_INS     = 30;
  localparam int B_REM     = 31;
  localparam int B_IEN     = 4;
  localparam int B_PRESENT = 8;
  localparam int B_EMPTY   = 2;
  localparam int B_LEVEL   = 17;
  localparam int B_DTX     = 0;
  localparam int B_DRX     = 1;
  localparam int B_DSUM    = 8;

  localparam logic [REG_W-1:0] CTRL_RST   = 32'h0000_0300;
  localparam logic [REG_W-1:0] STATE_RST  = 32'h0000_0100;
  localparam logic [REG_W-1:0] BLKSZ_RST  = 32'h0000_0200;
  localparam logic [REG_W-1:0] BCNT_RST   = 32'h0000_0200;
  localparam logic [REG_W-1:0] TMO_RST    = 32'hFFFF_FF40;
  localparam logic [REG_W-1:0] CTRL_SELFC = 32'h0000_0007;
endpackage

// File: rtl/irqs_w1c_bank.sv
module irqs_w1c_bank #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] d_o
);
  // set dominates clear so an event is never lost to a racing write
  always_comb d_o = (q_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) q_o <= RST_VAL;
    else     q_o <= d_o;
  end
endmodule

// File: rtl/irqs_xfer_count.sv
module irqs_xfer_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  input  logic [W-1:0] dec_amt_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_hit_o
);
  logic [W-1:0] dec_res;

  always_comb begin
    dec_res    = (cnt_o > dec_amt_i) ? cnt_o - dec_amt_i : '0;
    zero_hit_o = dec_i && !load_i && (dec_res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (dec_i)  cnt_o <= dec_res;
  end
endmodule

// File: rtl/irqs_unit.sv
module irqs_unit import irqs_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int DMA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_no_resp,
  input  logic              ev_cmd_done,
  input  logic              ev_data_done,
  input  logic              ev_auto_done,
  input  logic              ev_sdio,
  input  logic              card_insert,
  input  logic              card_remove,
  input  logic              xfer_pulse,
  input  logic [CNT_W-1:0]  xfer_bytes,
  input  logic              dma_tx_done,
  input  logic              dma_rx_done,
  input  logic              data_ready,
  output logic              irq
);
  localparam int DMA_PAD = REG_W - DMA_W;

  logic wr_ctrl, wr_tmo, wr_blksz, wr_bcnt, wr_mask, wr_istat, wr_state, wr_dstat;
  logic rem_eff, zero_hit;
  logic [REG_W-1:0] ctrl_q, ctrl_d, tmo_q, blksz_q, bcnt_q, mask_q, mask_d;
  logic [REG_W-1:0] raw_set, raw_clr, raw_q, raw_d;
  logic [REG_W-1:0] st_set, st_clr, st_q, st_d, st_view;
  logic [DMA_W-1:0] dm_set, dm_clr, dm_q, dm_d;
  logic [CNT_W-1:0] xfer_cnt;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
    wr_tmo   = reg_wr && (reg_addr == OFF_TMO);
    wr_blksz = reg_wr && (reg_addr == OFF_BLKSZ);
    wr_bcnt  = reg_wr && (reg_addr == OFF_BCNT);
    wr_mask  = reg_wr && (reg_addr == OFF_IMASK);
    wr_istat = reg_wr && ((reg_addr == OFF_ISTAT_M) || (reg_addr == OFF_ISTAT_R));
    wr_state = reg_wr && (reg_addr == OFF_STATE);
    wr_dstat = reg_wr && (reg_addr == OFF_DSTAT);
    rem_eff  = card_remove && !card_insert;
  end

  // next-state values of the plain registers feed the interrupt gate
  always_comb begin
    ctrl_d = wr_ctrl ? (reg_wdata & ~CTRL_SELFC) : ctrl_q;
    mask_d = wr_mask ? reg_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      tmo_q   <= TMO_RST;
      blksz_q <= BLKSZ_RST;
      bcnt_q  <= BCNT_RST;
      mask_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
      if (wr_tmo)   tmo_q   <= reg_wdata;
      if (wr_blksz) blksz_q <= reg_wdata;
      if (wr_bcnt)  bcnt_q  <= reg_wdata;
    end
  end

  irqs_xfer_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(wr_bcnt), .load_val_i(reg_wdata[CNT_W-1:0]),
    .dec_i(xfer_pulse), .dec_amt_i(xfer_bytes), .cnt_o(xfer_cnt), .zero_hit_o(zero_hit)
  );

  always_comb begin
    raw_set            = '0;
    raw_set[B_NORESP]  = ev_no_resp;
    raw_set[B_CMDDONE] = ev_cmd_done;
    raw_set[B_DATDONE] = ev_data_done | zero_hit;
    raw_set[B_AUTODN]  = ev_auto_done;
    raw_set[B_SDIO]    = ev_sdio;
    raw_set[B_INS]     = card_insert;
    raw_set[B_REM]     = rem_eff;
    raw_clr            = wr_istat ? reg_wdata : '0;
    raw_clr[B_INS]     = raw_clr[B_INS] | rem_eff;
    raw_clr[B_REM]     = raw_clr[B_REM] | card_insert;

    st_set             = '0;
    st_set[B_PRESENT]  = card_insert;
    st_clr             = wr_state ? reg_wdata : '0;
    st_clr[B_PRESENT]  = st_clr[B_PRESENT] | rem_eff;

    dm_set             = '0;
    dm_set[B_DTX]      = dma_tx_done;
    dm_set[B_DRX]      = dma_rx_done;
    dm_set[B_DSUM]     = dma_tx_done | dma_rx_done;
    dm_clr             = wr_dstat ? reg_wdata[DMA_W-1:0] : '0;
  end

  irqs_w1c_bank #(.W(REG_W), .RST_VAL('0)) u_raw (
    .clk(clk), .rst(rst), .set_i(raw_set), .clr_i(raw_clr), .q_o(raw_q), .d_o(raw_d)
  );

  irqs_w1c_bank #(.W(REG_W), .RST_VAL(STATE_RST)) u_state (
    .clk(clk), .rst(rst), .set_i(st_set), .clr_i(st_clr), .q_o(st_q), .d_o(st_d)
  );

  irqs_w1c_bank #(.W(DMA_W), .RST_VAL('0)) u_dstat (
    .clk(clk), .rst(rst), .set_i(dm_set), .clr_i(dm_clr), .q_o(dm_q), .d_o(dm_d)
  );

  always_comb begin
    st_view = st_q;
    if (data_ready) st_view[B_LEVEL] = 1'b1;
    else            st_view[B_EMPTY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ctrl_d[B_IEN] && |(raw_d & mask_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFF_CTRL:    reg_rdata <= ctrl_q;
        OFF_TMO:     reg_rdata <= tmo_q;
        OFF_BLKSZ:   reg_rdata <= blksz_q;
        OFF_BCNT:    reg_rdata <= bcnt_q;
        OFF_IMASK:   reg_rdata <= mask_q;
        OFF_ISTAT_M: reg_rdata <= raw_q & mask_q;
        OFF_ISTAT_R: reg_rdata <= raw_q;
        OFF_STATE:   reg_rdata <= st_view;
        OFF_DSTAT:   reg_rdata <= {{DMA_PAD{1'b0}}, dm_q};
        default:     reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irqs_unit_chk.sv
module irqs_unit_chk import irqs_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int DMA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  raw_q,
  input logic [REG_W-1:0]  st_q,
  input logic [DMA_W-1:0]  dm_q,
  input logic [CNT_W-1:0]  xfer_cnt,
  input logic              ev_cmd_done,
  input logic              card_insert,
  input logic              card_remove,
  input logic              dma_tx_done,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata
);
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ctrl_q[B_IEN] && |(raw_q & mask_q)));

  // R2
  ctrl_selfclr_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[2:0] == 3'b000);

  // R12
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_cmd_done |=> raw_q[B_CMDDONE]);

  // R7
  card_in_chk: assert property (@(posedge clk) disable iff (rst)
    card_insert |=> (raw_q[B_INS] && !raw_q[B_REM] && st_q[B_PRESENT]));

  // R7
  card_out_chk: assert property (@(posedge clk) disable iff (rst)
    (card_remove && !card_insert) |=> (!raw_q[B_INS] && raw_q[B_REM] && !st_q[B_PRESENT]));

  // R11
  dma_tx_chk: assert property (@(posedge clk) disable iff (rst)
    dma_tx_done |=> (dm_q[B_DTX] && dm_q[B_DSUM]));

  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFF_BCNT) |=> xfer_cnt == $past(reg_wdata[CNT_W-1:0]));
endmodule

bind irqs_unit irqs_unit_chk #(.CNT_W(CNT_W), .DMA_W(DMA_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ctrl_q(ctrl_q), .mask_q(mask_q), .raw_q(raw_q),
  .st_q(st_q), .dm_q(dm_q), .xfer_cnt(xfer_cnt), .ev_cmd_done(ev_cmd_done),
  .card_insert(card_insert), .card_remove(card_remove), .dma_tx_done(dma_tx_done),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/irqs_unit_bench.sv
`timescale 1ns/1ps
module irqs_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_no_resp = 0, ev_cmd_done = 0, ev_data_done = 0, ev_auto_done = 0, ev_sdio = 0;
  logic card_insert = 0, card_remove = 0, xfer_pulse = 0;
  logic [31:0] xfer_bytes = '0;
  logic dma_tx_done = 0, dma_rx_done = 0, data_ready = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irqs_unit u_irqs_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_no_resp(ev_no_resp),
    .ev_cmd_done(ev_cmd_done), .ev_data_done(ev_data_done), .ev_auto_done(ev_auto_done),
    .ev_sdio(ev_sdio), .card_insert(card_insert), .card_remove(card_remove),
    .xfer_pulse(xfer_pulse), .xfer_bytes(xfer_bytes), .dma_tx_done(dma_tx_done),
    .dma_rx_done(dma_rx_done), .data_ready(data_ready), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic xfer(input logic [31:0] n);
    @(negedge clk); xfer_pulse = 1; xfer_bytes = n;
    @(negedge clk); xfer_pulse = 0;
  endtask

  task automatic t_reset;
    rdchk("R1 ctrl", 12'h000, 32'h300);
    rdchk("R1 timeout", 12'h008, 32'hFFFFFF40);
    rdchk("R1 blksz", 12'h010, 32'h200);
    rdchk("R1 bytecnt", 12'h014, 32'h200);
    rdchk("R1 mask", 12'h030, 32'h0);
    rdchk("R1 raw", 12'h038, 32'h0);
    rdchk("R1 dma", 12'h088, 32'h0);
    rdchk("R1 status", 12'h03C, 32'h104);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(12'h000, 32'h0000_0317);
    rdchk("R2 selfclear", 12'h000, 32'h310);
  endtask

  task automatic t_events;
    @(negedge clk); ev_no_resp = 1; ev_cmd_done = 1; ev_data_done = 1; ev_auto_done = 1; ev_sdio = 1;
    @(negedge clk); ev_no_resp = 0; ev_cmd_done = 0; ev_data_done = 0; ev_auto_done = 0; ev_sdio = 0;
    rdchk("R6 event bits", 12'h038, 32'h0001_400E);
    chk("R5 irq masked off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    wr(12'h030, 32'h0000_000C);
    rdchk("R3 masked view", 12'h034, 32'h0000_000C);
    rdchk("R3 raw view", 12'h038, 32'h0001_400E);
    chk("R5 irq on", {31'b0, irq}, 32'h1);
    wr(12'h000, 32'h0000_0300);
    chk("R5 irq gated by enable", {31'b0, irq}, 32'h0);
    wr(12'h000, 32'h0000_0310);
    chk("R5 irq re-enabled", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_clear;
    wr(12'h034, 32'h0000_0004);
    rdchk("R4 clear via masked offset", 12'h038, 32'h0001_400A);
    wr(12'h038, 32'h0000_0008);
    rdchk("R4 clear via raw offset", 12'h038, 32'h0001_4002);
    chk("R5 irq drops", {31'b0, irq}, 32'h0);
    wr(12'h038, 32'hFFFF_FFFF);
    rdchk("R4 clear all", 12'h038, 32'h0);
  endtask

  task automatic t_card;
    @(negedge clk); card_insert = 1;
    @(negedge clk); card_insert = 0;
    rdchk("R7 insert raw", 12'h038, 32'h4000_0000);
    rdchk("R10 status no data", 12'h03C, 32'h0000_0104);
    data_ready = 1;
    rdchk("R10 status data ready", 12'h03C, 32'h0002_0100);
    data_ready = 0;
    @(negedge clk); card_remove = 1;
    @(negedge clk); card_remove = 0;
    rdchk("R7 remove raw", 12'h038, 32'h8000_0000);
    rdchk("R7 remove status", 12'h03C, 32'h0000_0004);
  endtask

  task automatic t_state_clr;
    @(negedge clk); card_insert = 1;
    @(negedge clk); card_insert = 0;
    rdchk("R7 present again", 12'h03C, 32'h0000_0104);
    wr(12'h03C, 32'h0000_0100);
    rdchk("R9 status cleared", 12'h03C, 32'h0000_0004);
    wr(12'h038, 32'hFFFF_FFFF);
  endtask

  task automatic t_xfer;
    wr(12'h014, 32'd10);
    rdchk("R8 bytecnt stored", 12'h014, 32'd10);
    xfer(32'd4);
    xfer(32'd4);
    rdchk("R8 not yet zero", 12'h038, 32'h0);
    xfer(32'd4);
    rdchk("R8 saturate to zero", 12'h038, 32'h8);
    wr(12'h038, 32'h8);
    xfer(32'd4);
    rdchk("R8 zero stays zero", 12'h038, 32'h8);
    wr(12'h038, 32'h8);
    @(negedge clk); reg_wr = 1; reg_addr = 12'h014; reg_wdata = 32'd8; xfer_pulse = 1; xfer_bytes = 32'd8;
    @(negedge clk); reg_wr = 0; xfer_pulse = 0;
    rdchk("R8 load beats pulse", 12'h038, 32'h0);
    xfer(32'd8);
    rdchk("R8 drain after load", 12'h038, 32'h8);
    wr(12'h038, 32'hFFFF_FFFF);
  endtask

  task automatic t_dma;
    @(negedge clk); dma_tx_done = 1;
    @(negedge clk); dma_tx_done = 0;
    rdchk("R11 tx bits", 12'h088, 32'h101);
    @(negedge clk); dma_rx_done = 1;
    @(negedge clk); dma_rx_done = 0;
    rdchk("R11 rx bits", 12'h088, 32'h103);
    wr(12'h088, 32'hFFFF_FC01);
    rdchk("R11 partial clear", 12'h088, 32'h102);
    wr(12'h088, 32'h0000_03FF);
    rdchk("R11 clear low bits", 12'h088, 32'h0);
  endtask

  task automatic t_race;
    wr(12'h030, 32'h4000_0004);
    @(negedge clk);
    ev_cmd_done = 1; card_insert = 1;
    reg_wr = 1; reg_addr = 12'h038; reg_wdata = 32'h4000_0004;
    @(negedge clk);
    ev_cmd_done = 0; card_insert = 0; reg_wr = 0;
    chk("R12 irq stays up", {31'b0, irq}, 32'h1);
    rdchk("R12 event beats clear", 12'h038, 32'h4000_0004);
    wr(12'h038, 32'hFFFF_FFFF);
    chk("R5 irq after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rdhold;
    rdchk("R13 read ctrl", 12'h000, 32'h310);
    wr(12'h000, 32'h0000_0300);
    @(negedge clk);
    chk("R13 rdata held", reg_rdata, 32'h310);
    rdchk("R13 fresh read", 12'h000, 32'h300);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_ctrl();
    t_events();
    t_mask();
    t_clear();
    t_card();
    t_state_clr();
    t_xfer();
    t_dma();
    t_race();
    t_rdhold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule